// File: doc/BRIEF.md
# Exception Entry Sequencer

This block performs the switch from normal execution into a handler. Each cycle the core presents its architectural context: program counter, status word, stack register (R15), vector base, and a delay-slot flag. Alongside this it presents a pending exception code and an interrupt request with its vector and priority level. When the one-cycle `take` strobe is high and an event qualifies, the block commits the whole entry at that clock edge. It writes the handler address, the new status word, the saved copies of PC, status and R15, and the event register for the class of event taken. One cycle later it raises `done`.

Arbitration is fixed. A pending exception always wins over an interrupt. When the block bit in the status word is already set, an exception is escalated to the power-on reset code, except for the one code that is exempt. In the same state an interrupt is dropped unless the core has just been woken from a halt. An interrupt is also dropped unless its level is strictly above the mask field. The handler address depends on the event class: reset-like, TLB miss, trap, general exception or interrupt.

Control is a two-state machine. `ST_WAIT` is the idle state. `ST_ACK` is the state in which `done` is high. The transition `commit` (take with a qualifying event) moves either state to `ST_ACK`. Without a commit, either state moves to `ST_WAIT`.

Top module: `excent_seq`

## Requirements
- R1: After reset, `new_pc` is 0xA0000000. `new_sr` is 0x700000F0, which means BL (bit 28), RB (bit 29) and MD (bit 30) are set and the mask field SR[7:4] is 0xF. The saved registers, `expevt` and `intevt` are zero, and `done` is low.
- R2: When `exc_pending` and `irq_req` are both high, the exception is taken. `intevt` keeps its value.
- R3: With SR bit 28 (BL) set, any exception code other than 0x1E0 is recorded and handled as code 0x000. Code 0x1E0 is kept as it is.
- R4: With BL set, an interrupt is ignored unless `halt_wake` is high. Every entry made while BL is set pulses `wake_clr` for one cycle, together with `done`.
- R5: An interrupt is accepted only if `irq_level` is strictly greater than SR[7:4]. Otherwise no register changes and `done` stays low.
- R6: On entry, `saved_sr` receives the incoming SR and `saved_r15` receives R15. `new_sr` equals the incoming SR with bits 28, 29 and 30 set.
- R7: When `in_dslot` is high, `saved_pc` is the incoming PC minus 2, and `dslot_clr` pulses for one cycle together with `done`.
- R8: Exception codes 0x000, 0x020 and 0x140 also clear SR bit 15 and set SR[7:4] to 0xF. The new PC for these codes is 0xA0000000.
- R9: Codes 0x040 and 0x060 go to VBR+0x400. Code 0x160 goes to VBR+0x100 and adds 2 to the saved PC, after any delay-slot correction. Every other code goes to VBR+0x100.
- R10: An exception writes its effective code to `expevt` and leaves `intevt` unchanged. An interrupt writes its vector to `intevt`, leaves `expevt` unchanged, and goes to VBR+0x600.
- R11: All updates commit at the clock edge where `take` is high, and `done` is high for the following cycle. Without `take`, no output register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| take | input | 1 | One-cycle strobe: commit an entry if an event qualifies |
| cur_pc | input | 32 | PC of the interrupted instruction |
| cur_sr | input | 32 | Current status word |
| cur_r15 | input | 32 | Current R15 (stack) value |
| vbr | input | 32 | Vector base |
| in_dslot | input | 1 | Interrupted instruction is in a delay slot |
| halt_wake | input | 1 | Core was woken from a halt by the interrupt |
| exc_pending | input | 1 | An exception code is pending |
| exc_code | input | 12 | Pending exception code |
| irq_req | input | 1 | Interrupt controller has a request |
| irq_vector | input | 12 | Interrupt vector code |
| irq_level | input | 4 | Interrupt priority level |
| new_pc | output | 32 | Handler address |
| new_sr | output | 32 | Status word after entry |
| saved_pc | output | 32 | Saved PC |
| saved_sr | output | 32 | Saved status word |
| saved_r15 | output | 32 | Saved R15 |
| expevt | output | 12 | Last exception event code |
| intevt | output | 12 | Last interrupt event code |
| done | output | 1 | Entry completed in the previous cycle |
| wake_clr | output | 1 | Clear the halt-wake flag (entry taken with BL set) |
| dslot_clr | output | 1 | Clear the delay-slot flags |

## Verification
The bench targets block-bit escalation. A design that skipped it would jump to the vector base instead of 0xA0000000 for code 0x180, or would wrongly escalate the exempt code 0x1E0. It probes the level comparison at equality, where a `>=` compare would take an interrupt the mask should hold off. It also combines a trap with a delay slot: a design that applied only one of the two corrections would save a PC off by 2. Finally, it raises exception and interrupt together, to catch a design that lets the interrupt win or that overwrites `intevt` during an exception entry.

// File: rtl/excent_pkg.sv
`timescale 1ns/1ps
package excent_pkg;

    // Status word bit positions
    localparam int SR_FD       = 15;
    localparam int SR_BL       = 28;
    localparam int SR_RB       = 29;
    localparam int SR_MD       = 30;
    localparam int SR_MASK_LSB = 4;

    // Event codes with special handling
    localparam logic [11:0] C_POWERON  = 12'h000;
    localparam logic [11:0] C_MANRESET = 12'h020;
    localparam logic [11:0] C_MULTIHIT = 12'h140;
    localparam logic [11:0] C_TLBM_RD  = 12'h040;
    localparam logic [11:0] C_TLBM_WR  = 12'h060;
    localparam logic [11:0] C_TRAP     = 12'h160;
    localparam logic [11:0] C_BL_KEEP  = 12'h1E0;

    typedef enum logic [2:0] {
        CLS_NONE,
        CLS_RESET,
        CLS_TLBMISS,
        CLS_GENERAL,
        CLS_TRAP,
        CLS_IRQ
    } cls_e;

    typedef enum logic {
        ST_WAIT,
        ST_ACK
    } st_e;

endpackage

// File: rtl/excent_arbiter.sv
`timescale 1ns/1ps
module excent_arbiter
    import excent_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int LVL_W  = 4
) (
    input  logic              exc_pending,
    input  logic [CODE_W-1:0] exc_code,
    input  logic              irq_req,
    input  logic [LVL_W-1:0]  irq_level,
    input  logic [LVL_W-1:0]  sr_mask,
    input  logic              sr_bl,
    input  logic              halt_wake,
    output logic              accept,
    output logic              take_exc,
    output logic [CODE_W-1:0] eff_code,
    output logic              wake_clr
);

    logic irq_ok;

    always_comb begin
        take_exc = exc_pending;
        eff_code = exc_code;
        if (exc_pending && sr_bl && (exc_code != CODE_W'(C_BL_KEEP))) begin
            eff_code = CODE_W'(C_POWERON);
        end
        irq_ok   = irq_req && !exc_pending && (!sr_bl || halt_wake)
                   && (irq_level > sr_mask);
        accept   = exc_pending || irq_ok;
        wake_clr = accept && sr_bl;
    end

endmodule

// File: rtl/excent_classify.sv
`timescale 1ns/1ps
module excent_classify
    import excent_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic              accept,
    input  logic              take_exc,
    input  logic [CODE_W-1:0] code,
    output cls_e              cls
);

    always_comb begin
        cls = CLS_NONE;
        if (accept && !take_exc) begin
            cls = CLS_IRQ;
        end else if (accept) begin
            case (code)
                CODE_W'(C_POWERON),
                CODE_W'(C_MANRESET),
                CODE_W'(C_MULTIHIT): cls = CLS_RESET;
                CODE_W'(C_TLBM_RD),
                CODE_W'(C_TLBM_WR):  cls = CLS_TLBMISS;
                CODE_W'(C_TRAP):     cls = CLS_TRAP;
                default:             cls = CLS_GENERAL;
            endcase
        end
    end

endmodule

// File: rtl/excent_target.sv
`timescale 1ns/1ps
module excent_target
    import excent_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              LVL_W    = 4,
    parameter logic [XLEN-1:0] RESET_PC = 32'hA000_0000,
    parameter logic [XLEN-1:0] OFS_TLB  = 32'h0000_0400,
    parameter logic [XLEN-1:0] OFS_GEN  = 32'h0000_0100,
    parameter logic [XLEN-1:0] OFS_IRQ  = 32'h0000_0600
) (
    input  cls_e            cls,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [XLEN-1:0] cur_sr,
    input  logic [XLEN-1:0] vbr,
    input  logic            dslot,
    output logic [XLEN-1:0] tgt_pc,
    output logic [XLEN-1:0] tgt_sr,
    output logic [XLEN-1:0] tgt_spc
);

    always_comb begin
        tgt_sr        = cur_sr;
        tgt_sr[SR_BL] = 1'b1;
        tgt_sr[SR_RB] = 1'b1;
        tgt_sr[SR_MD] = 1'b1;

        tgt_spc = cur_pc;
        if (dslot) begin
            tgt_spc = tgt_spc - XLEN'(2);
        end
        if (cls == CLS_TRAP) begin
            tgt_spc = tgt_spc + XLEN'(2);
        end

        tgt_pc = vbr + OFS_GEN;
        case (cls)
            CLS_RESET: begin
                tgt_sr[SR_FD]                  = 1'b0;
                tgt_sr[SR_MASK_LSB +: LVL_W]   = '1;
                tgt_pc                         = RESET_PC;
            end
            CLS_TLBMISS: tgt_pc = vbr + OFS_TLB;
            CLS_IRQ:     tgt_pc = vbr + OFS_IRQ;
            default:     tgt_pc = vbr + OFS_GEN;
        endcase
    end

endmodule

// File: rtl/excent_seq.sv
`timescale 1ns/1ps
module excent_seq
    import excent_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              CODE_W   = 12,
    parameter int              LVL_W    = 4,
    parameter logic [XLEN-1:0] RESET_PC = 32'hA000_0000,
    parameter logic [XLEN-1:0] OFS_TLB  = 32'h0000_0400,
    parameter logic [XLEN-1:0] OFS_GEN  = 32'h0000_0100,
    parameter logic [XLEN-1:0] OFS_IRQ  = 32'h0000_0600
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [XLEN-1:0]   cur_sr,
    input  logic [XLEN-1:0]   cur_r15,
    input  logic [XLEN-1:0]   vbr,
    input  logic              in_dslot,
    input  logic              halt_wake,
    input  logic              exc_pending,
    input  logic [CODE_W-1:0] exc_code,
    input  logic              irq_req,
    input  logic [CODE_W-1:0] irq_vector,
    input  logic [LVL_W-1:0]  irq_level,
    output logic [XLEN-1:0]   new_pc,
    output logic [XLEN-1:0]   new_sr,
    output logic [XLEN-1:0]   saved_pc,
    output logic [XLEN-1:0]   saved_sr,
    output logic [XLEN-1:0]   saved_r15,
    output logic [CODE_W-1:0] expevt,
    output logic [CODE_W-1:0] intevt,
    output logic              done,
    output logic              wake_clr,
    output logic              dslot_clr
);

    localparam logic [XLEN-1:0] SR_RST =
        (XLEN'(1) << SR_BL) | (XLEN'(1) << SR_RB) | (XLEN'(1) << SR_MD) |
        (XLEN'((1 << LVL_W) - 1) << SR_MASK_LSB);

    logic              acc;
    logic              is_exc;
    logic [CODE_W-1:0] eff_code;
    logic              wclr_nx;
    cls_e              cls;
    logic [XLEN-1:0]   tgt_pc;
    logic [XLEN-1:0]   tgt_sr;
    logic [XLEN-1:0]   tgt_spc;
    logic              commit;
    st_e               state;
    st_e               state_nx;

    excent_arbiter #(.CODE_W(CODE_W), .LVL_W(LVL_W)) u_arb (
        .exc_pending (exc_pending),
        .exc_code    (exc_code),
        .irq_req     (irq_req),
        .irq_level   (irq_level),
        .sr_mask     (cur_sr[SR_MASK_LSB +: LVL_W]),
        .sr_bl       (cur_sr[SR_BL]),
        .halt_wake   (halt_wake),
        .accept      (acc),
        .take_exc    (is_exc),
        .eff_code    (eff_code),
        .wake_clr    (wclr_nx)
    );

    excent_classify #(.CODE_W(CODE_W)) u_cls (
        .accept   (acc),
        .take_exc (is_exc),
        .code     (eff_code),
        .cls      (cls)
    );

    excent_target #(
        .XLEN(XLEN), .LVL_W(LVL_W), .RESET_PC(RESET_PC),
        .OFS_TLB(OFS_TLB), .OFS_GEN(OFS_GEN), .OFS_IRQ(OFS_IRQ)
    ) u_tgt (
        .cls     (cls),
        .cur_pc  (cur_pc),
        .cur_sr  (cur_sr),
        .vbr     (vbr),
        .dslot   (in_dslot),
        .tgt_pc  (tgt_pc),
        .tgt_sr  (tgt_sr),
        .tgt_spc (tgt_spc)
    );

    assign commit = take && acc;

    // Next-state logic
    always_comb begin
        state_nx = ST_WAIT;
        unique case (state)
            ST_WAIT: state_nx = commit ? ST_ACK : ST_WAIT;
            ST_ACK:  state_nx = commit ? ST_ACK : ST_WAIT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_WAIT;
        else        state <= state_nx;
    end

    assign done = (state == ST_ACK);

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            new_pc    <= RESET_PC;
            new_sr    <= SR_RST;
            saved_pc  <= '0;
            saved_sr  <= '0;
            saved_r15 <= '0;
            expevt    <= '0;
            intevt    <= '0;
            wake_clr  <= 1'b0;
            dslot_clr <= 1'b0;
        end else begin
            wake_clr  <= commit && wclr_nx;
            dslot_clr <= commit && in_dslot;
            if (commit) begin
                new_pc    <= tgt_pc;
                new_sr    <= tgt_sr;
                saved_pc  <= tgt_spc;
                saved_sr  <= cur_sr;
                saved_r15 <= cur_r15;
                if (is_exc) expevt <= eff_code;
                else        intevt <= irq_vector;
            end
        end
    end

endmodule

// File: rtl/excent_seq_chk.sv
`timescale 1ns/1ps
module excent_seq_chk
    import excent_pkg::*;
#(
    parameter int              XLEN    = 32,
    parameter int              CODE_W  = 12,
    parameter int              LVL_W   = 4,
    parameter logic [XLEN-1:0] OFS_IRQ = 32'h0000_0600
) (
    input logic              clk,
    input logic              rst_n,
    input logic              take,
    input logic              exc_pending,
    input logic              irq_req,
    input logic [LVL_W-1:0]  irq_level,
    input logic [XLEN-1:0]   cur_sr,
    input logic [XLEN-1:0]   cur_r15,
    input logic [XLEN-1:0]   vbr,
    input logic [XLEN-1:0]   new_pc,
    input logic [XLEN-1:0]   new_sr,
    input logic [XLEN-1:0]   saved_pc,
    input logic [XLEN-1:0]   saved_sr,
    input logic [XLEN-1:0]   saved_r15,
    input logic [CODE_W-1:0] expevt,
    input logic [CODE_W-1:0] intevt,
    input logic              done
);

    // R11
    done_follows_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(take));

    // R11
    hold_without_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> ($stable(new_pc) && $stable(saved_pc) && $stable(expevt) && $stable(intevt)));

    // R6
    status_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (new_sr[SR_BL] && new_sr[SR_RB] && new_sr[SR_MD]));

    // R6
    saved_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (saved_sr == $past(cur_sr) && saved_r15 == $past(cur_r15)));

    // R10
    irq_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !$past(exc_pending)) |-> (new_pc == $past(vbr) + OFS_IRQ));

    // R5
    level_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !exc_pending && irq_req && (irq_level <= cur_sr[SR_MASK_LSB +: LVL_W])) |=> !done);

    // R2
    intevt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && exc_pending) |=> $stable(intevt));

endmodule

bind excent_seq excent_seq_chk #(
    .XLEN(XLEN), .CODE_W(CODE_W), .LVL_W(LVL_W), .OFS_IRQ(OFS_IRQ)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .take        (take),
    .exc_pending (exc_pending),
    .irq_req     (irq_req),
    .irq_level   (irq_level),
    .cur_sr      (cur_sr),
    .cur_r15     (cur_r15),
    .vbr         (vbr),
    .new_pc      (new_pc),
    .new_sr      (new_sr),
    .saved_pc    (saved_pc),
    .saved_sr    (saved_sr),
    .saved_r15   (saved_r15),
    .expevt      (expevt),
    .intevt      (intevt),
    .done        (done)
);

// File: tb/excent_seq_test.sv
`timescale 1ns/1ps
module excent_seq_test;

    typedef struct packed {
        logic        exc;
        logic [11:0] code;
        logic        irq;
        logic [11:0] vec;
        logic [3:0]  lvl;
        logic        bl;
        logic        ds;
        logic        wake;
        logic        acc;
        logic [31:0] pc;
        logic [31:0] spc;
        logic [31:0] sr;
        logic [11:0] evt;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t TBL [NV] = '{
        '{1'b1,12'h0E0,1'b0,12'h000,4'd0,1'b0,1'b0,1'b0,1'b1,32'h8C000100,32'h8C001000,32'h70008030,12'h0E0},
        '{1'b1,12'h040,1'b0,12'h000,4'd0,1'b0,1'b0,1'b0,1'b1,32'h8C000400,32'h8C001000,32'h70008030,12'h040},
        '{1'b1,12'h060,1'b0,12'h000,4'd0,1'b0,1'b1,1'b0,1'b1,32'h8C000400,32'h8C000FFE,32'h70008030,12'h060},
        '{1'b1,12'h160,1'b0,12'h000,4'd0,1'b0,1'b0,1'b0,1'b1,32'h8C000100,32'h8C001002,32'h70008030,12'h160},
        '{1'b1,12'h160,1'b0,12'h000,4'd0,1'b0,1'b1,1'b0,1'b1,32'h8C000100,32'h8C001000,32'h70008030,12'h160},
        '{1'b1,12'h140,1'b0,12'h000,4'd0,1'b0,1'b0,1'b0,1'b1,32'hA0000000,32'h8C001000,32'h700000F0,12'h140},
        '{1'b1,12'h020,1'b0,12'h000,4'd0,1'b0,1'b0,1'b0,1'b1,32'hA0000000,32'h8C001000,32'h700000F0,12'h020},
        '{1'b1,12'h180,1'b0,12'h000,4'd0,1'b1,1'b0,1'b0,1'b1,32'hA0000000,32'h8C001000,32'h700000F0,12'h000},
        '{1'b1,12'h1E0,1'b0,12'h000,4'd0,1'b1,1'b0,1'b0,1'b1,32'h8C000100,32'h8C001000,32'h70008030,12'h1E0},
        '{1'b0,12'h000,1'b1,12'h320,4'd5,1'b0,1'b0,1'b0,1'b1,32'h8C000600,32'h8C001000,32'h70008030,12'h320},
        '{1'b0,12'h000,1'b1,12'h3A0,4'd3,1'b0,1'b0,1'b0,1'b0,32'h0,32'h0,32'h0,12'h0},
        '{1'b0,12'h000,1'b1,12'h3C0,4'd9,1'b1,1'b0,1'b0,1'b0,32'h0,32'h0,32'h0,12'h0},
        '{1'b0,12'h000,1'b1,12'h3C0,4'd9,1'b1,1'b0,1'b1,1'b1,32'h8C000600,32'h8C001000,32'h70008030,12'h3C0},
        '{1'b1,12'h0A0,1'b1,12'h300,4'd15,1'b0,1'b0,1'b0,1'b1,32'h8C000100,32'h8C001000,32'h70008030,12'h0A0},
        '{1'b0,12'h000,1'b1,12'h2E0,4'd6,1'b0,1'b1,1'b0,1'b1,32'h8C000600,32'h8C000FFE,32'h70008030,12'h2E0}
    };

    localparam logic [31:0] SR_USER = 32'h0000_8030;
    localparam logic [31:0] SR_BLK  = 32'h1000_8030;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        take = 1'b0;
    logic [31:0] cur_pc = 32'h8C00_1000;
    logic [31:0] cur_sr = SR_USER;
    logic [31:0] cur_r15 = '0;
    logic [31:0] vbr = 32'h8C00_0000;
    logic        in_dslot = 1'b0;
    logic        halt_wake = 1'b0;
    logic        exc_pending = 1'b0;
    logic [11:0] exc_code = '0;
    logic        irq_req = 1'b0;
    logic [11:0] irq_vector = '0;
    logic [3:0]  irq_level = '0;
    logic [31:0] new_pc, new_sr, saved_pc, saved_sr, saved_r15;
    logic [11:0] expevt, intevt;
    logic        done, wake_clr, dslot_clr;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    excent_seq uut (
        .clk(clk), .rst_n(rst_n), .take(take), .cur_pc(cur_pc), .cur_sr(cur_sr),
        .cur_r15(cur_r15), .vbr(vbr), .in_dslot(in_dslot), .halt_wake(halt_wake),
        .exc_pending(exc_pending), .exc_code(exc_code), .irq_req(irq_req),
        .irq_vector(irq_vector), .irq_level(irq_level), .new_pc(new_pc),
        .new_sr(new_sr), .saved_pc(saved_pc), .saved_sr(saved_sr),
        .saved_r15(saved_r15), .expevt(expevt), .intevt(intevt), .done(done),
        .wake_clr(wake_clr), .dslot_clr(dslot_clr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report;
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        report();
    end

    initial begin
        logic [31:0] p_pc, p_spc, p_sr;
        logic [11:0] p_exp, p_int;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 new_pc", new_pc, 32'hA000_0000);
        chk("R1 new_sr", new_sr, 32'h7000_00F0);
        chk("R1 saved_pc", saved_pc, 32'h0);
        chk("R1 saved_sr", saved_sr, 32'h0);
        chk("R1 saved_r15", saved_r15, 32'h0);
        chk("R1 expevt", 32'(expevt), 32'h0);
        chk("R1 intevt", 32'(intevt), 32'h0);
        chk("R1 done", 32'(done), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 pending event without take changes nothing
        exc_pending = 1'b1; exc_code = 12'h0E0;
        irq_req = 1'b1; irq_vector = 12'h3E0; irq_level = 4'd15;
        repeat (2) @(negedge clk);
        chk("R11 no take done", 32'(done), 32'h0);
        chk("R11 no take pc", new_pc, 32'hA000_0000);
        chk("R11 no take expevt", 32'(expevt), 32'h0);

        for (int i = 0; i < NV; i++) begin
            p_pc = new_pc; p_spc = saved_pc; p_sr = new_sr;
            p_exp = expevt; p_int = intevt;
            exc_pending = TBL[i].exc; exc_code = TBL[i].code;
            irq_req = TBL[i].irq; irq_vector = TBL[i].vec; irq_level = TBL[i].lvl;
            cur_sr = TBL[i].bl ? SR_BLK : SR_USER;
            in_dslot = TBL[i].ds; halt_wake = TBL[i].wake;
            cur_r15 = 32'h0000_1000 + 32'(i);
            take = 1'b1;
            @(negedge clk);
            take = 1'b0;
            chk("R2 R4 R5 R11 done", 32'(done), 32'(TBL[i].acc));
            if (TBL[i].acc) begin
                chk("R8 R9 R10 new_pc", new_pc, TBL[i].pc);
                chk("R6 R8 new_sr", new_sr, TBL[i].sr);
                chk("R7 R9 saved_pc", saved_pc, TBL[i].spc);
                chk("R6 saved_sr", saved_sr, cur_sr);
                chk("R6 saved_r15", saved_r15, cur_r15);
                chk("R4 wake_clr", 32'(wake_clr), 32'(TBL[i].bl));
                chk("R7 dslot_clr", 32'(dslot_clr), 32'(TBL[i].ds));
                if (TBL[i].exc) begin
                    chk("R3 R10 expevt", 32'(expevt), 32'(TBL[i].evt));
                    chk("R2 intevt kept", 32'(intevt), 32'(p_int));
                end else begin
                    chk("R10 intevt", 32'(intevt), 32'(TBL[i].evt));
                    chk("R10 expevt kept", 32'(expevt), 32'(p_exp));
                end
            end else begin
                chk("R4 R5 pc kept", new_pc, p_pc);
                chk("R4 R5 saved_pc kept", saved_pc, p_spc);
                chk("R4 R5 sr kept", new_sr, p_sr);
                chk("R4 R5 intevt kept", 32'(intevt), 32'(p_int));
            end
            @(negedge clk);
            chk("R11 done single", 32'(done), 32'h0);
        end
        report();
    end

endmodule